// File: doc/BRIEF.md
# Per-Pin Alternate-Function GPIO Port

This block manages an eight-pin port in which every pin is either a general-purpose I/O under software control or is lent to a synchronous serial peripheral. Software sees three registers through a simple write-strobe and combinational-read interface. The first is an output data latch. The second is a direction register. The third is an ownership register that decides, pin by pin, who drives the pad.

When a pin is owned by the peripheral, the peripheral's output value and output enable reach the pad directly. The GPIO direction and latch settings for that pin then have no effect. Pad levels pass through a two-flop synchronizer. The synchronized levels are delivered to the peripheral and are also what software reads from the data register.

Some pins have no ownership bit. In the default build these are pin 2, whose position is reserved, and pin 7, which serves an asynchronous peripheral that manages the pin through GPIO. These pins always remain under GPIO control.

Top module: `gpio_altport`

## Requirements
- R1: After reset the direction and ownership registers read zero and every pad output enable is low, so all pins are GPIO inputs.
- R2: A write to address 0 stores bits [7:0] in the data latch. On a GPIO pin whose direction bit is 1, the pad drives that latched bit with output enable high from the cycle after the write.
- R3: A read of address 0 returns the synchronized pad levels in bits [7:0] and zero in bits [15:8]. A pad change becomes visible after exactly two rising clock edges.
- R4: A write to address 1 sets the direction byte. A pin whose direction bit becomes 1 drives, in the very next cycle, the value already held in the data latch. Direction writes never alter the data latch.
- R5: A pin whose ownership bit (address 2) is 1 drives the peripheral's output and output enable on its pad. The GPIO direction and latch values for that pin are ignored.
- R6: Ownership bits exist only where ASSIGN_MASK is 1 (default 8'h7B). Bit 2 (reserved) and bit 7 read 0 whatever is written, and those pins stay under GPIO control.
- R7: The peripheral input bus carries each pad level after two rising edges, regardless of ownership. After only one edge it still shows the old level.
- R8: Reads of address 1 and address 2 return the stored byte with bits [15:8] zero. Address 3 reads all zeros, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 data, 1 direction, 2 ownership, 3 none |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| per_out | input | 8 | Peripheral output value per pin |
| per_oe | input | 8 | Peripheral output enable per pin |
| per_in | output | 8 | Synchronized pad levels toward the peripheral |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |

## Verification
The hardest situation to reach is a pin whose latch was written while it was still an input and is later turned to an output. That pin must drive the old latch value, and only on pins that are not lent to the peripheral. The stimulus reaches it in two ways. Directed sequences write the latch first and the direction second. Random sequences interleave writes to all three registers with random peripheral drive, so that ownership flips under pins that already hold a latched value and a set direction. Synchronizer latency is probed by sampling the peripheral input after one edge and again after two.

// File: rtl/gpio_altport_pkg.sv
package gpio_altport_pkg;
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_OWN  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_altport_rstsync.sv
module gpio_altport_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_s_n = stage_q[1];
endmodule

// File: rtl/gpio_altport_sync.sv
module gpio_altport_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, meta_d;
  logic [W-1:0] safe_q, safe_d;

  always_comb begin
    meta_d = d_i;
    safe_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      safe_q <= '0;
    end else begin
      meta_q <= meta_d;
      safe_q <= safe_d;
    end
  end

  assign q_o = safe_q;

  // Cycles since reset, for the latency check only.
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= 2'd0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  // R3 R7
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/gpio_altport_regs.sv
module gpio_altport_regs
  import gpio_altport_pkg::*;
#(
  parameter int             NPINS       = 8,
  parameter int             REG_W       = 16,
  parameter logic [NPINS-1:0] ASSIGN_MASK = 8'h7B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [1:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [NPINS-1:0] pins_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [NPINS-1:0] latch_o,
  output logic [NPINS-1:0] dir_o,
  output logic [NPINS-1:0] own_o
);
  localparam int PAD_W = REG_W - NPINS;

  reg_sel_e         sel;
  logic             latch_en, dir_en, own_en;
  logic [NPINS-1:0] latch_q, latch_d;
  logic [NPINS-1:0] dir_q, dir_d;
  logic [NPINS-1:0] own_q, own_d;
  logic             unused_hi;

  assign sel       = reg_sel_e'(addr_i);
  assign unused_hi = ^wdata_i[REG_W-1:NPINS];

  always_comb begin
    latch_en = wr_i && (sel == SEL_DATA);
    dir_en   = wr_i && (sel == SEL_DIR);
    own_en   = wr_i && (sel == SEL_OWN);
    latch_d  = wdata_i[NPINS-1:0];
    dir_d    = wdata_i[NPINS-1:0];
    own_d    = wdata_i[NPINS-1:0] & ASSIGN_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= '0;
    else if (latch_en) latch_q <= latch_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_en) dir_q <= dir_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      own_q <= '0;
    else if (own_en) own_q <= own_d;
  end

  always_comb begin
    unique case (sel)
      SEL_DATA: rdata_o = {{PAD_W{1'b0}}, pins_i};
      SEL_DIR:  rdata_o = {{PAD_W{1'b0}}, dir_q};
      SEL_OWN:  rdata_o = {{PAD_W{1'b0}}, own_q};
      default:  rdata_o = '0;
    endcase
  end

  assign latch_o = latch_q;
  assign dir_o   = dir_q;
  assign own_o   = own_q;

  // R6
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q & ~ASSIGN_MASK) == '0);

  // R2
  data_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == 2'd0) |=> (latch_q == $past(wdata_i[NPINS-1:0])));

  // R4
  dir_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i != 2'd0) |=> $stable(latch_q));

  // R8
  none_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == 2'd3) |=> ($stable(dir_q) && $stable(own_q)));
endmodule

// File: rtl/gpio_altport_mux.sv
module gpio_altport_mux #(
  parameter int NPINS = 8
) (
  input  logic [NPINS-1:0] own_i,
  input  logic [NPINS-1:0] latch_i,
  input  logic [NPINS-1:0] dir_i,
  input  logic [NPINS-1:0] per_out_i,
  input  logic [NPINS-1:0] per_oe_i,
  output logic [NPINS-1:0] pad_out_o,
  output logic [NPINS-1:0] pad_oe_o
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    always_comb begin
      if (own_i[p]) begin
        pad_out_o[p] = per_out_i[p];
        pad_oe_o[p]  = per_oe_i[p];
      end else begin
        pad_out_o[p] = latch_i[p];
        pad_oe_o[p]  = dir_i[p];
      end
    end
  end
endmodule

// File: rtl/gpio_altport.sv
module gpio_altport #(
  parameter int               NPINS       = 8,
  parameter int               REG_W       = 16,
  parameter logic [NPINS-1:0] ASSIGN_MASK = 8'h7B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [NPINS-1:0] per_out,
  input  logic [NPINS-1:0] per_oe,
  output logic [NPINS-1:0] per_in,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe
);
  logic             rst_s_n;
  logic [NPINS-1:0] pins_s, latch_w, dir_w, own_w;

  gpio_altport_rstsync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  gpio_altport_sync #(.W(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_s_n),
    .d_i   (pad_in),
    .q_o   (pins_s)
  );

  gpio_altport_regs #(
    .NPINS       (NPINS),
    .REG_W       (REG_W),
    .ASSIGN_MASK (ASSIGN_MASK)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .wr_i    (reg_wr),
    .addr_i  (reg_addr),
    .wdata_i (reg_wdata),
    .pins_i  (pins_s),
    .rdata_o (reg_rdata),
    .latch_o (latch_w),
    .dir_o   (dir_w),
    .own_o   (own_w)
  );

  gpio_altport_mux #(.NPINS(NPINS)) u_mux (
    .own_i     (own_w),
    .latch_i   (latch_w),
    .dir_i     (dir_w),
    .per_out_i (per_out),
    .per_oe_i  (per_oe),
    .pad_out_o (pad_out),
    .pad_oe_o  (pad_oe)
  );

  assign per_in = pins_s;

  // R1
  reset_inputs_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(rst_s_n) |-> (pad_oe == '0));
endmodule

// File: tb/gpio_altport_tb_top.sv
`timescale 1ns/1ps
module gpio_altport_tb_top;
  localparam logic [7:0] MASK = 8'h7B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [7:0]  per_out = '0, per_oe = '0, per_in;
  logic [7:0]  pad_in = '0, pad_out, pad_oe;

  int checks = 0;
  int failures = 0;
  logic [7:0] m_latch = '0, m_dir = '0, m_own = '0;

  always #2 clk = ~clk;

  gpio_altport dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .per_out(per_out),
    .per_oe(per_oe), .per_in(per_in), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe)
  );

  function automatic logic [7:0] exp_out();
    return (m_own & per_out) | (~m_own & m_latch);
  endfunction
  function automatic logic [7:0] exp_oe();
    return (m_own & per_oe) | (~m_own & m_dir);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_wr = 1'b0;
    case (a)
      2'd0: m_latch = d[7:0];
      2'd1: m_dir = d[7:0];
      2'd2: m_own = d[7:0] & MASK;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic chk_pads(input string tag);
    @(negedge clk);
    chk({tag, " pad_out"}, {8'h0, pad_out}, {8'h0, exp_out()});
    chk({tag, " pad_oe"}, {8'h0, pad_oe}, {8'h0, exp_oe()});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int seed;
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    rd(2'd1, v); chk("R1 dir", v, 16'h0);
    rd(2'd2, v); chk("R1 own", v, 16'h0);
    chk_pads("R1");

    // R2/R4: latch while input, then turn to output
    wr(2'd0, 16'hFFA5);
    chk_pads("R2 latched not driven");
    wr(2'd1, 16'h00FF);
    chk_pads("R4 drives held latch");
    chk("R4 latch value", {8'h0, pad_out}, 16'h00A5);
    wr(2'd0, 16'h003C);
    chk_pads("R2 new value driven");

    // R8 readback and address 3
    rd(2'd1, v); chk("R8 dir read", v, 16'h00FF);
    wr(2'd3, 16'hFFFF);
    rd(2'd3, v); chk("R8 none read", v, 16'h0);
    rd(2'd1, v); chk("R8 none write no effect", v, 16'h00FF);

    // R6 reserved ownership bits
    per_out = 8'hFF; per_oe = 8'h00;
    wr(2'd2, 16'hFFFF);
    rd(2'd2, v); chk("R6 own read", v, 16'h007B);
    chk_pads("R6 pins 2 and 7 stay GPIO");
    chk("R6 pin7 oe", {15'h0, pad_oe[7]}, 16'h1);

    // R5 peripheral owns pad, GPIO ignored
    per_out = 8'h5A; per_oe = 8'hF0;
    wr(2'd1, 16'h0000);
    chk_pads("R5 gpio ignored");
    wr(2'd2, 16'h0000);
    chk_pads("R5 released");

    // R3/R7 synchronizer latency
    @(negedge clk); pad_in = 8'h96;
    @(negedge clk);
    chk("R7 one edge old", {8'h0, per_in}, 16'h0);
    @(negedge clk);
    chk("R7 two edges", {8'h0, per_in}, 16'h0096);
    rd(2'd0, v); chk("R3 data read pins", v, 16'h0096);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 4);
      per_out = 8'($urandom); per_oe = 8'($urandom);
      if (op == 4) begin
        logic [7:0] p;
        p = 8'($urandom);
        @(negedge clk); pad_in = p;
        repeat (2) @(negedge clk);
        chk("R7 random", {8'h0, per_in}, {8'h0, p});
        rd(2'd0, v); chk("R3 random", v, {8'h0, p});
      end else begin
        wr(2'(op), 16'($urandom));
        chk_pads("R5 random");
        if (op != 0) begin
          rd(2'(op), v);
          chk("R8 random", v, (op == 1) ? {8'h0, m_dir} :
                              (op == 2) ? {8'h0, m_own} : 16'h0);
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule